// File: doc/BRIEF.md
# Console Port Select Router

This block is the console register set of a processor: a receive status register, a receive buffer, a transmit status register and a transmit buffer, all reached over a small register bus. Each word written to the transmit buffer carries a 4-bit select field in bits 11:8, and that field decides where the word goes. It can become a character for the console output line, a data byte or a command byte for a floppy sub-controller, a read of a 128-byte communications region, or a miscellaneous control function.

On the receive side, one buffer collects answers from several sources. These are console characters, communications-region bytes tagged with 0x300, and status or data words that the floppy sub-controller hands in over a valid/ready port. Each direction has a DONE flag, an interrupt enable and an interrupt request. Software drives them through the status registers and through reads of the receive buffer or writes to the transmit buffer. The serial line and the floppy state machine sit outside the block.

Top module: `con_sel_router`

## Requirements
- R1: A transmit-buffer write with select 0 presents bits 7:0 on `co_data` with `co_valid` high from the next cycle, and holds both steady until `co_ready` is seen high. Select 1 gives a one-cycle `fl_byte_valid` pulse in the next cycle, and select 9 gives a one-cycle `fl_cmd_valid` pulse in the next cycle. In both cases the byte appears on `fl_out_byte`.
- R2: A transmit-buffer write with select 3 uses bits 6:0 as a byte index into the communications region. It loads the receive buffer with 0x0300 OR that byte and sets receive DONE.
- R3: Miscellaneous code 3 (bits 7:0 of a select-F write) clears both the warm-start byte (index 101) and the cold-start byte (index 102). Code 4 clears only the cold-start byte.
- R4: Miscellaneous code 1 produces a one-cycle `sw_done` pulse, and code 2 produces a one-cycle `reboot_req` pulse, each in the cycle after the write.
- R5: A read of the receive buffer (address 1) returns its full word, then clears receive DONE and the receive interrupt, and zeroes bits 15:8. Bits 15, 14 and 13 are the error, overrun and framing bits.
- R6: A transmit-buffer write clears transmit DONE and its interrupt. With select 0, DONE is set again when the character is accepted. With select 1 or 9, DONE is set again by an `fl_tx_done` pulse. Any other select leaves DONE set right after the write.
- R7: In either status register, writing IE=1 while DONE=1 and IE=0 raises the interrupt, and writing IE=0 drops it. While IE=1, setting DONE raises the interrupt.
- R8: After reset: transmit status reads 0x0080 and receive status reads 0x0000. The receive buffer is 0. The communications region is all zero except index 100 (value 1), indices 106 to 109 (version parameters), and the warm-start and cold-start bytes (parameters, default 0).
- R9: A console character on `ci_valid` loads 0x00cc into the receive buffer and sets DONE. If DONE was already set, it loads 0xC0cc instead, which adds the error and overrun bits. A break loads 0xA000, which is error plus framing with data 0.
- R10: The status registers read back only bit 7 (DONE) and bit 6 (IE). Writes change only IE.
- R11: `fl_rx_ready` is high only while receive DONE is 0 and no region read loads the buffer. An accepted floppy word is stored as-is and sets DONE. When loads collide, a region read wins over a floppy word, and a floppy word wins over a console character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects at the clock edge) |
| reg_addr | input | 2 | 0 receive status, 1 receive buffer, 2 transmit status, 3 transmit buffer |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| ci_valid | input | 1 | Console input character strobe |
| ci_data | input | 8 | Console input character |
| ci_break | input | 1 | Qualifies `ci_valid` as a break condition |
| co_valid | output | 1 | Console output character pending |
| co_data | output | 8 | Console output character |
| co_ready | input | 1 | Output line accepts the character |
| fl_byte_valid | output | 1 | One-cycle pulse: floppy data byte |
| fl_cmd_valid | output | 1 | One-cycle pulse: floppy command byte |
| fl_out_byte | output | 8 | Byte for the floppy sub-controller |
| fl_tx_done | input | 1 | Floppy sub-controller has taken the last transmit word |
| fl_rx_valid | input | 1 | Floppy sub-controller offers a receive word |
| fl_rx_word | input | 16 | Receive word from the floppy sub-controller |
| fl_rx_ready | output | 1 | Receive buffer can take the floppy word |
| sw_done | output | 1 | One-cycle software-done pulse |
| reboot_req | output | 1 | One-cycle reboot request pulse |
| rx_irq | output | 1 | Receive interrupt request |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
Every register effect of a bus write or read, and every injected character or floppy word, is due one edge later. The bench drives on falling edges and samples at the next falling edge or after it.

Floppy and miscellaneous pulses also come one edge after the write and last exactly one cycle. A scoreboard queue, filled before each write, is drained by a monitor that samples every falling edge, so a late, early or doubled pulse is flagged.

Transmit DONE for select 0 returns only one edge after `co_ready` is seen. The bench holds `co_ready` low across several cycles to check that DONE stays low and `co_data` stays put.

// File: rtl/con_sel_pkg.sv
// Package: shared constants and types of the console select router.
// Assumes 16-bit register words and a select field in bits 11:8.
package con_sel_pkg;
    localparam int WORD_W     = 16;
    localparam int BYTE_W     = 8;
    localparam int SEL_LSB    = 8;
    localparam int SEL_W      = 4;
    localparam int COMM_DEPTH = 128;
    localparam int COMM_AW    = $clog2(COMM_DEPTH);
    localparam int VER_CNT    = 4;

    localparam int IDX_GH     = 100;
    localparam int IDX_WARM   = 101;
    localparam int IDX_COLD   = 102;
    localparam int IDX_VER0   = 106;

    localparam logic [SEL_W-1:0] SEL_CHAR = 4'h0;
    localparam logic [SEL_W-1:0] SEL_FDAT = 4'h1;
    localparam logic [SEL_W-1:0] SEL_COMM = 4'h3;
    localparam logic [SEL_W-1:0] SEL_FCMD = 4'h9;
    localparam logic [SEL_W-1:0] SEL_MISC = 4'hF;

    localparam logic [BYTE_W-1:0] MISC_SWDONE = 8'd1;
    localparam logic [BYTE_W-1:0] MISC_BOOT   = 8'd2;
    localparam logic [BYTE_W-1:0] MISC_CLRWS  = 8'd3;
    localparam logic [BYTE_W-1:0] MISC_CLRCS  = 8'd4;

    localparam int CSR_DONE_BIT = 7;
    localparam int CSR_IE_BIT   = 6;
    localparam logic [WORD_W-1:0] RX_ERR  = 16'h8000;
    localparam logic [WORD_W-1:0] RX_OVR  = 16'h4000;
    localparam logic [WORD_W-1:0] RX_FRM  = 16'h2000;
    localparam logic [WORD_W-1:0] COMM_TAG = 16'h0300;

    typedef enum logic [1:0] {
        REG_RXCS = 2'd0,
        REG_RXDB = 2'd1,
        REG_TXCS = 2'd2,
        REG_TXDB = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic to_char;
        logic to_fdat;
        logic to_fcmd;
        logic to_comm;
        logic to_misc;
        logic to_other;
    } route_t;

    typedef struct packed {
        logic swdone;
        logic boot;
        logic clr_warm;
        logic clr_cold;
    } misc_t;
endpackage

// File: rtl/con_dir_flags.sv
// Module: DONE / IE / interrupt-request flags of one console direction.
// Assumes set_done wins over clr_done in the same cycle, and that a
// status write is applied before a same-cycle DONE event.
module con_dir_flags #(
    parameter logic RESET_DONE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic csr_wr,
    input  logic wr_ie,
    input  logic set_done,
    input  logic clr_done,
    output logic done,
    output logic ie,
    output logic irq
);
    logic done_n, ie_n, irq_n;

    // Next-state rules for the three flags.
    always_comb begin
        done_n = done;
        ie_n   = ie;
        irq_n  = irq;
        if (csr_wr) begin
            ie_n = wr_ie;
            if (!wr_ie)
                irq_n = 1'b0;
            else if (done && !ie)
                irq_n = 1'b1;
        end
        if (clr_done) begin
            done_n = 1'b0;
            irq_n  = 1'b0;
        end
        if (set_done) begin
            done_n = 1'b1;
            if (ie_n)
                irq_n = 1'b1;
        end
    end

    // Flag registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= RESET_DONE;
            ie   <= 1'b0;
            irq  <= 1'b0;
        end else begin
            done <= done_n;
            ie   <= ie_n;
            irq  <= irq_n;
        end
    end

    assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (done && ie));

    assert_ie_rise_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && wr_ie && done && !ie && !clr_done) |=> irq);
endmodule

// File: rtl/con_comm_region.sv
// Module: 128-byte communications region with a reset image.
// Assumes only the warm/cold-start bytes are ever changed after reset.
module con_comm_region
    import con_sel_pkg::*;
#(
    parameter logic [BYTE_W-1:0]         WARM_INIT = 8'h00,
    parameter logic [BYTE_W-1:0]         COLD_INIT = 8'h00,
    parameter logic [VER_CNT*BYTE_W-1:0] VER_INIT  = 32'h04030201
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_warm,
    input  logic               clr_cold,
    input  logic [COMM_AW-1:0] rd_idx,
    output logic [BYTE_W-1:0]  rd_byte
);
    logic [BYTE_W-1:0] mem [COMM_DEPTH];

    function automatic logic [BYTE_W-1:0] init_byte(input int idx);
        if (idx == IDX_GH)
            return 8'd1;
        if (idx == IDX_WARM)
            return WARM_INIT;
        if (idx == IDX_COLD)
            return COLD_INIT;
        if (idx >= IDX_VER0 && idx < IDX_VER0 + VER_CNT)
            return VER_INIT[(idx - IDX_VER0)*BYTE_W +: BYTE_W];
        return '0;
    endfunction

    // Region storage: reset image, then selective clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < COMM_DEPTH; i++)
                mem[i] <= init_byte(i);
        end else begin
            if (clr_warm)
                mem[IDX_WARM] <= '0;
            if (clr_cold)
                mem[IDX_COLD] <= '0;
        end
    end

    // Combinational read port.
    assign rd_byte = mem[rd_idx];

    assert_cold_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cold |=> (mem[IDX_COLD] == '0));

    assert_warm_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_warm |=> (mem[IDX_WARM] == '0));
endmodule

// File: rtl/con_tx_decode.sv
// Module: decodes a transmit-buffer word into a route and a misc function.
// Assumes wr_en is the transmit-buffer write strobe; purely combinational.
module con_tx_decode
    import con_sel_pkg::*;
(
    input  logic              wr_en,
    input  logic [WORD_W-1:0] word,
    output route_t            route,
    output misc_t             misc,
    output logic [COMM_AW-1:0] comm_idx
);
    logic [SEL_W-1:0]  sel;
    logic [BYTE_W-1:0] code;
    logic              unused_hi;

    assign sel       = word[SEL_LSB +: SEL_W];
    assign code      = word[BYTE_W-1:0];
    assign comm_idx  = word[COMM_AW-1:0];
    assign unused_hi = ^word[WORD_W-1:SEL_LSB+SEL_W];

    // Select-field steering.
    always_comb begin
        route = '0;
        if (wr_en) begin
            unique case (sel)
                SEL_CHAR: route.to_char  = 1'b1;
                SEL_FDAT: route.to_fdat  = 1'b1;
                SEL_FCMD: route.to_fcmd  = 1'b1;
                SEL_COMM: route.to_comm  = 1'b1;
                SEL_MISC: route.to_misc  = 1'b1;
                default:  route.to_other = 1'b1;
            endcase
        end
    end

    // Miscellaneous function codes; code 3 clears both bytes.
    always_comb begin
        misc = '0;
        if (route.to_misc) begin
            misc.swdone   = (code == MISC_SWDONE);
            misc.boot     = (code == MISC_BOOT);
            misc.clr_warm = (code == MISC_CLRWS);
            misc.clr_cold = (code == MISC_CLRWS) || (code == MISC_CLRCS);
        end
    end
endmodule

// File: rtl/con_sel_router.sv
// Module: console register set with select-field steering of transmit
// words and a shared, tagged receive buffer.
// Assumes one bus access per cycle; receive-load priority is region read,
// then floppy word, then console character.
module con_sel_router
    import con_sel_pkg::*;
#(
    parameter logic [BYTE_W-1:0]         WARM_INIT = 8'h00,
    parameter logic [BYTE_W-1:0]         COLD_INIT = 8'h00,
    parameter logic [VER_CNT*BYTE_W-1:0] VER_INIT  = 32'h04030201
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [1:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        ci_valid,
    input  logic [7:0]  ci_data,
    input  logic        ci_break,
    output logic        co_valid,
    output logic [7:0]  co_data,
    input  logic        co_ready,
    output logic        fl_byte_valid,
    output logic        fl_cmd_valid,
    output logic [7:0]  fl_out_byte,
    input  logic        fl_tx_done,
    input  logic        fl_rx_valid,
    input  logic [15:0] fl_rx_word,
    output logic        fl_rx_ready,
    output logic        sw_done,
    output logic        reboot_req,
    output logic        rx_irq,
    output logic        tx_irq
);
    logic rxcs_wr, txcs_wr, rxdb_rd, txdb_wr;
    route_t route;
    misc_t  misc;
    logic [COMM_AW-1:0] comm_idx;
    logic [BYTE_W-1:0]  comm_byte;
    logic [WORD_W-1:0]  rx_buf;
    logic rx_done, rx_ie, tx_done, tx_ie;
    logic comm_load, fl_take, ci_take, rx_set, tx_set, co_accept;

    assign rxcs_wr = reg_wr && (reg_addr == REG_RXCS);
    assign txcs_wr = reg_wr && (reg_addr == REG_TXCS);
    assign txdb_wr = reg_wr && (reg_addr == REG_TXDB);
    assign rxdb_rd = reg_rd && (reg_addr == REG_RXDB);

    con_tx_decode u_decode (
        .wr_en    (txdb_wr),
        .word     (reg_wdata),
        .route    (route),
        .misc     (misc),
        .comm_idx (comm_idx)
    );

    con_comm_region #(
        .WARM_INIT (WARM_INIT),
        .COLD_INIT (COLD_INIT),
        .VER_INIT  (VER_INIT)
    ) u_comm (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_warm (misc.clr_warm),
        .clr_cold (misc.clr_cold),
        .rd_idx   (comm_idx),
        .rd_byte  (comm_byte)
    );

    // Receive-buffer load arbitration.
    assign comm_load   = route.to_comm;
    assign fl_rx_ready = !rx_done && !comm_load;
    assign fl_take     = fl_rx_valid && fl_rx_ready;
    assign ci_take     = ci_valid && !comm_load && !fl_take;
    assign rx_set      = comm_load || fl_take || ci_take;

    // Receive buffer contents.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_buf <= '0;
        end else if (comm_load) begin
            rx_buf <= COMM_TAG | {{(WORD_W-BYTE_W){1'b0}}, comm_byte};
        end else if (fl_take) begin
            rx_buf <= fl_rx_word;
        end else if (ci_take) begin
            if (ci_break)
                rx_buf <= RX_ERR | RX_FRM;
            else if (rx_done && !rxdb_rd)
                rx_buf <= RX_ERR | RX_OVR | {{(WORD_W-BYTE_W){1'b0}}, ci_data};
            else
                rx_buf <= {{(WORD_W-BYTE_W){1'b0}}, ci_data};
        end else if (rxdb_rd) begin
            rx_buf[WORD_W-1:BYTE_W] <= '0;
        end
    end

    con_dir_flags #(.RESET_DONE(1'b0)) u_rx_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .csr_wr   (rxcs_wr),
        .wr_ie    (reg_wdata[CSR_IE_BIT]),
        .set_done (rx_set),
        .clr_done (rxdb_rd),
        .done     (rx_done),
        .ie       (rx_ie),
        .irq      (rx_irq)
    );

    // Transmit completion events.
    assign co_accept = co_valid && co_ready;
    assign tx_set    = co_accept || fl_tx_done ||
                       route.to_comm || route.to_misc || route.to_other;

    con_dir_flags #(.RESET_DONE(1'b1)) u_tx_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .csr_wr   (txcs_wr),
        .wr_ie    (reg_wdata[CSR_IE_BIT]),
        .set_done (tx_set),
        .clr_done (txdb_wr),
        .done     (tx_done),
        .ie       (tx_ie),
        .irq      (tx_irq)
    );

    // Console output holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            co_valid <= 1'b0;
            co_data  <= '0;
        end else if (route.to_char) begin
            co_valid <= 1'b1;
            co_data  <= reg_wdata[BYTE_W-1:0];
        end else if (co_accept) begin
            co_valid <= 1'b0;
        end
    end

    // One-cycle floppy and miscellaneous pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fl_byte_valid <= 1'b0;
            fl_cmd_valid  <= 1'b0;
            fl_out_byte   <= '0;
            sw_done       <= 1'b0;
            reboot_req    <= 1'b0;
        end else begin
            fl_byte_valid <= route.to_fdat;
            fl_cmd_valid  <= route.to_fcmd;
            if (route.to_fdat || route.to_fcmd)
                fl_out_byte <= reg_wdata[BYTE_W-1:0];
            sw_done    <= misc.swdone;
            reboot_req <= misc.boot;
        end
    end

    // Register read multiplexer.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            REG_RXCS: begin
                reg_rdata[CSR_DONE_BIT] = rx_done;
                reg_rdata[CSR_IE_BIT]   = rx_ie;
            end
            REG_RXDB: reg_rdata = rx_buf;
            REG_TXCS: begin
                reg_rdata[CSR_DONE_BIT] = tx_done;
                reg_rdata[CSR_IE_BIT]   = tx_ie;
            end
            default:  reg_rdata = '0;
        endcase
    end

    assert_co_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (co_valid && !co_ready && !txdb_wr) |=> (co_valid && $stable(co_data)));

    assert_comm_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        comm_load |=> (rx_buf[WORD_W-1:BYTE_W] == 8'h03 && rx_done));

    assert_rd_strips_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rxdb_rd && !rx_set) |=> (rx_buf[WORD_W-1:BYTE_W] == '0 && !rx_done && !rx_irq));

    assert_txwr_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (route.to_char && !fl_tx_done && !co_accept) |=> (!tx_done && !tx_irq));

    assert_inject_stored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fl_take |=> (rx_buf == $past(fl_rx_word) && rx_done));
endmodule

// File: tb/con_sel_router_bench.sv
module con_sel_router_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        ci_valid = 1'b0, ci_break = 1'b0;
    logic [7:0]  ci_data = 8'h0;
    logic        co_valid, co_ready = 1'b1;
    logic [7:0]  co_data;
    logic        fl_byte_valid, fl_cmd_valid;
    logic [7:0]  fl_out_byte;
    logic        fl_tx_done = 1'b0, fl_rx_valid = 1'b0, fl_rx_ready;
    logic [15:0] fl_rx_word = 16'h0;
    logic        sw_done, reboot_req, rx_irq, tx_irq;

    int n_checks = 0, n_fail = 0;
    bit finished = 0;
    logic [15:0] expq[$];
    string       tagq[$];

    always #2 clk = ~clk;

    con_sel_router #(
        .WARM_INIT (8'h5A),
        .COLD_INIT (8'hA5),
        .VER_INIT  (32'h44332211)
    ) u_con_sel_router (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ci_valid(ci_valid), .ci_data(ci_data), .ci_break(ci_break),
        .co_valid(co_valid), .co_data(co_data), .co_ready(co_ready),
        .fl_byte_valid(fl_byte_valid), .fl_cmd_valid(fl_cmd_valid),
        .fl_out_byte(fl_out_byte), .fl_tx_done(fl_tx_done),
        .fl_rx_valid(fl_rx_valid), .fl_rx_word(fl_rx_word),
        .fl_rx_ready(fl_rx_ready), .sw_done(sw_done), .reboot_req(reboot_req),
        .rx_irq(rx_irq), .tx_irq(tx_irq)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push_exp(input string tag, input logic [15:0] ev);
        expq.push_back(ev);
        tagq.push_back(tag);
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic read_check(input string tag, input logic [1:0] a, input logic [15:0] exp);
        logic [15:0] v;
        bus_read(a, v);
        check(tag, v, exp);
    endtask

    task automatic comm_check(input string tag, input int idx, input logic [7:0] exp);
        bus_write(2'd3, 16'h0300 | 16'(idx));
        read_check({tag, " rx DONE after region read"}, 2'd0, 16'h0080);
        read_check({tag, " region byte"}, 2'd1, 16'h0300 | {8'h00, exp});
        read_check("R5 DONE cleared by buffer read", 2'd0, 16'h0000);
    endtask

    task automatic ci_send(input logic [7:0] d, input logic brk);
        @(negedge clk);
        ci_valid = 1'b1; ci_data = d; ci_break = brk;
        @(negedge clk);
        ci_valid = 1'b0; ci_break = 1'b0;
    endtask

    task automatic pulse_tx_done();
        @(negedge clk);
        fl_tx_done = 1'b1;
        @(negedge clk);
        fl_tx_done = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Monitor: pops expected output events as the design produces them.
    always @(negedge clk) begin
        logic [15:0] ev;
        bit          got;
        #1;
        if (rst_n) begin
            for (int k = 0; k < 5; k++) begin
                got = 0;
                case (k)
                    0: if (co_valid && co_ready) begin got = 1; ev = {8'h00, co_data}; end
                    1: if (fl_byte_valid) begin got = 1; ev = {8'h10, fl_out_byte}; end
                    2: if (fl_cmd_valid)  begin got = 1; ev = {8'h20, fl_out_byte}; end
                    3: if (sw_done)       begin got = 1; ev = 16'h3000; end
                    default: if (reboot_req) begin got = 1; ev = 16'h4000; end
                endcase
                if (got) begin
                    if (expq.size() == 0) begin
                        check("R1 R4 unexpected output event", ev, 16'hFFFF);
                    end else begin
                        check(tagq.pop_front(), ev, expq.pop_front());
                    end
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R8 reset state
        read_check("R8 rx status after reset", 2'd0, 16'h0000);
        read_check("R8 tx status after reset", 2'd2, 16'h0080);
        read_check("R8 rx buffer after reset", 2'd1, 16'h0000);
        check("R8 irqs low after reset", {14'h0, rx_irq, tx_irq}, 16'h0000);

        // R2 region reads over the reset image
        comm_check("R2 R8 idx100", 100, 8'h01);
        comm_check("R2 R8 idx106", 106, 8'h11);
        comm_check("R2 R8 idx109", 109, 8'h44);
        comm_check("R2 R8 idx101", 101, 8'h5A);
        comm_check("R2 R8 idx5", 5, 8'h00);
        read_check("R6 tx DONE set after region read", 2'd2, 16'h0080);
        bus_write(2'd3, 16'h0364);
        read_check("R5 full word returned", 2'd1, 16'h0301);
        read_check("R5 tag stripped on second read", 2'd1, 16'h0001);

        // R1 R6 console output with back-pressure
        co_ready = 1'b0;
        push_exp("R1 console char", 16'h0042);
        bus_write(2'd3, 16'h0042);
        read_check("R6 tx DONE low while char pending", 2'd2, 16'h0000);
        repeat (3) @(negedge clk);
        #1 check("R1 char held", {7'h0, co_valid, co_data}, 16'h0142);
        @(negedge clk);
        co_ready = 1'b1;
        @(negedge clk);
        read_check("R6 tx DONE after accept", 2'd2, 16'h0080);
        push_exp("R1 console char 2", 16'h0041);
        bus_write(2'd3, 16'h0041);

        // R1 R6 floppy data and command
        push_exp("R1 floppy data", 16'h1055);
        bus_write(2'd3, 16'h0155);
        read_check("R6 tx DONE low until floppy done", 2'd2, 16'h0000);
        pulse_tx_done();
        read_check("R6 tx DONE after floppy done", 2'd2, 16'h0080);
        push_exp("R1 floppy command", 16'h2002);
        bus_write(2'd3, 16'h0902);
        pulse_tx_done();

        // R4 R3 miscellaneous functions
        push_exp("R4 software done", 16'h3000);
        bus_write(2'd3, 16'h0F01);
        push_exp("R4 reboot", 16'h4000);
        bus_write(2'd3, 16'h0F02);
        bus_write(2'd3, 16'h0F04);
        comm_check("R3 code4 clears cold", 102, 8'h00);
        comm_check("R3 code4 keeps warm", 101, 8'h5A);
        do_reset();
        comm_check("R8 cold restored", 102, 8'hA5);
        bus_write(2'd3, 16'h0F03);
        comm_check("R3 code3 clears warm", 101, 8'h00);
        comm_check("R3 code3 clears cold", 102, 8'h00);

        // R10 R7 status registers
        bus_write(2'd0, 16'hFFBF);
        read_check("R10 rx DONE not writable", 2'd0, 16'h0000);
        bus_write(2'd2, 16'hFFFF);
        read_check("R10 tx status bits", 2'd2, 16'h00C0);
        check("R7 IE rise with DONE raises tx irq", {15'h0, tx_irq}, 16'h0001);
        bus_write(2'd2, 16'h0000);
        check("R7 IE=0 drops tx irq", {15'h0, tx_irq}, 16'h0000);
        bus_write(2'd0, 16'h0040);
        check("R7 no rx irq without DONE", {15'h0, rx_irq}, 16'h0000);
        bus_write(2'd3, 16'h0364);
        check("R7 DONE with IE raises rx irq", {15'h0, rx_irq}, 16'h0001);
        read_check("R5 read returns word", 2'd1, 16'h0301);
        check("R5 read clears rx irq", {15'h0, rx_irq}, 16'h0000);
        bus_write(2'd0, 16'h0000);
        bus_write(2'd2, 16'h0040);
        push_exp("R1 floppy data 2", 16'h1077);
        bus_write(2'd3, 16'h0177);
        check("R6 tx write clears irq", {15'h0, tx_irq}, 16'h0000);
        pulse_tx_done();
        check("R7 DONE with IE raises tx irq", {15'h0, tx_irq}, 16'h0001);
        bus_write(2'd2, 16'h0000);

        // R9 console input
        ci_send(8'h61, 1'b0);
        read_check("R9 rx DONE after char", 2'd0, 16'h0080);
        read_check("R9 char word", 2'd1, 16'h0061);
        ci_send(8'h62, 1'b0);
        ci_send(8'h63, 1'b0);
        read_check("R9 overrun word", 2'd1, 16'hC063);
        ci_send(8'h00, 1'b1);
        read_check("R9 break word", 2'd1, 16'hA000);
        read_check("R5 error bits stripped", 2'd1, 16'h0000);

        // R11 floppy injection and priority
        #1 check("R11 ready when empty", {15'h0, fl_rx_ready}, 16'h0001);
        @(negedge clk);
        fl_rx_valid = 1'b1; fl_rx_word = 16'h0205;
        @(negedge clk);
        fl_rx_valid = 1'b0;
        #1 check("R11 not ready when full", {15'h0, fl_rx_ready}, 16'h0000);
        read_check("R11 floppy word stored", 2'd1, 16'h0205);
        @(negedge clk);
        fl_rx_valid = 1'b1; fl_rx_word = 16'h0201; ci_valid = 1'b1; ci_data = 8'h77;
        @(negedge clk);
        fl_rx_valid = 1'b0; ci_valid = 1'b0;
        read_check("R11 floppy beats console char", 2'd1, 16'h0201);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = 16'h0364;
        fl_rx_valid = 1'b1; fl_rx_word = 16'h0207;
        #1 check("R11 not ready during region read", {15'h0, fl_rx_ready}, 16'h0000);
        @(negedge clk);
        reg_wr = 1'b0; fl_rx_valid = 1'b0;
        read_check("R11 region read beats floppy", 2'd1, 16'h0301);
        read_check("R11 DONE cleared after read", 2'd0, 16'h0000);

        repeat (4) @(negedge clk);
        check("R1 R4 scoreboard drained", 16'(expq.size()), 16'h0000);
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule